// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This block sits beside one scatter-gather DMA channel, either the transmit or the receive direction, and decides when the processor is interrupted. The DMA engine pulses an input each time a packet completes, and the block keeps a count of packets that software has not yet serviced. An interrupt is raised in two cases. The first is when that count reaches a programmable threshold. The second is when a millisecond wait-bound timer runs out before the threshold is met. Software services the packets by sending one decrement command per packet, and acknowledges status bits by writing ones, which toggle them.

Two more events from the channel are latched as status: the end of the descriptor list and a bus or timeout error. A small register port gives access to the threshold, the wait bound, the packet count, the status and the interrupt enables. The threshold and the wait bound can only be changed while the channel is stopped. The millisecond tick comes from a prescaler on the system clock, and its division ratio is a parameter.

Top module: `pkt_coalesce_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Register map by `reg_addr`: 0 threshold, 1 wait bound, 2 packet count, 3 status, 4 enable. Any other address reads 0.
- R2: The count goes up by one on each cycle with `pkt_done`. It goes down by one on each write to address 2, and the write data is ignored. A decrement at zero is ignored. The count saturates at 2^CNT_W-1 instead of wrapping.
- R3: Status bit 0 is set on the clock edge after a cycle in which the threshold is nonzero and the count is at or above it. A threshold of 0 never sets bit 0.
- R4: The threshold bit behaves like a level. If it is acknowledged while the count still meets the threshold, it stays set. Once the count has dropped below the threshold, an acknowledge clears it.
- R5: With a nonzero wait bound W and a nonzero count, status bit 1 is set W*TICK_DIV clock edges after the latest `pkt_done` edge. Each new packet restarts this wait. Bit 1 is not set if the count meets a nonzero threshold when the wait expires.
- R6: A wait bound of 0 disables the timer, so bit 1 never sets.
- R7: A `list_end` pulse sets status bit 2, and a `bus_fault` pulse sets status bit 3.
- R8: A write to address 3 toggles every status bit written as 1, so writing a stale value after a reset sets those bits.
- R9: Writes to addresses 0 and 1 are ignored while `chan_run` is high. The wait bound keeps only the low WB_W bits, which gives a range of 0 to 1023 by default.
- R10: `irq` is a register. It goes high one cycle after any status bit whose enable bit (address 4, same position) is set, and low one cycle after no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_run | input | 1 | Channel running; blocks configuration writes |
| pkt_done | input | 1 | One-cycle pulse per completed packet |
| list_end | input | 1 | End-of-descriptor-list event pulse |
| bus_fault | input | 1 | Bus or timeout error event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data at `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with TICK_DIV=8, so a millisecond lasts eight cycles. This puts exact wait-bound expiry, restart on a new packet and threshold suppression within a few dozen cycles. CNT_W is set to 8, the same width as the threshold, so that saturation of the count at 255 can be reached with a few hundred packets. A seeded random phase mixes packet pulses and decrements against a fixed threshold, and compares the count and the interrupt each cycle with a bench model.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int REG_AW = 3;
   localparam int NSRC   = 4;
   localparam int ST_THR  = 0;
   localparam int ST_WAIT = 1;
   localparam int ST_EOL  = 2;
   localparam int ST_BUS  = 3;
   typedef enum logic [REG_AW-1:0] {
      RA_THRESH = 3'd0,
      RA_WAIT   = 3'd1,
      RA_COUNT  = 3'd2,
      RA_STATUS = 3'd3,
      RA_ENABLE = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/coal_ms_tick.sv
module coal_ms_tick #(
   parameter int DIV = 250000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("coal_ms_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick = !clr;
   end else begin : g_presc
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] presc_q;
      assign tick = !clr && (presc_q == LAST);
      always_ff @(posedge clk) begin
         if (rst || clr || tick) presc_q <= '0;
         else                    presc_q <= presc_q + 1'b1;
      end
      // ticks are at least two cycles apart when dividing
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick);
   end
endmodule

// File: rtl/coal_pkt_count.sv
module coal_pkt_count #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   logic inc_ok, dec_ok;
   assign inc_ok = inc && (cnt != MAXV);
   assign dec_ok = dec && (cnt != '0);

   always_ff @(posedge clk) begin
      if (rst)                  cnt <= '0;
      else if (inc_ok && !dec_ok) cnt <= cnt + 1'b1;
      else if (dec_ok && !inc_ok) cnt <= cnt - 1'b1;
   end

   assert_dec_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0 && dec && !inc) |=> (cnt == '0));
   assert_saturate_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt == MAXV && inc && !dec) |=> (cnt == MAXV));
   assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/coal_wait_timer.sv
module coal_wait_timer #(
   parameter int WB_W = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            run,
   input  logic            restart,
   input  logic            tick,
   input  logic [WB_W-1:0] bound,
   output logic            expire
);
   logic [WB_W-1:0] ms_q;
   assign expire = run && !restart && tick && (ms_q == bound - WB_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !run || restart || expire) ms_q <= '0;
      else if (tick)                        ms_q <= ms_q + 1'b1;
   end

   assert_expire_only_running_R6: assert property (@(posedge clk) disable iff (rst)
      expire |-> (bound != '0));
endmodule

// File: rtl/coal_irq_status.sv
module coal_irq_status #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   input  logic [N-1:0] tog,
   input  logic [N-1:0] en,
   output logic [N-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (rst) begin
         stat <= '0;
         irq  <= 1'b0;
      end else begin
         stat <= (stat ^ tog) | set;
         irq  <= |(stat & en);
      end
   end

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
      irq |-> $past((stat & en) != '0));
   assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set[0] |=> stat[0]);
endmodule

// File: rtl/pkt_coalesce_irq.sv
module pkt_coalesce_irq
   import coal_pkg::*;
#(
   parameter int THR_W    = 8,
   parameter int CNT_W    = 10,
   parameter int WB_W     = 10,
   parameter int DATA_W   = 16,
   parameter int TICK_DIV = 250000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              chan_run,
   input  logic              pkt_done,
   input  logic              list_end,
   input  logic              bus_fault,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   if (CNT_W < THR_W) begin : g_bad_cnt
      $error("pkt_coalesce_irq: CNT_W must cover THR_W");
   end
   if (DATA_W < CNT_W || DATA_W < WB_W || DATA_W < NSRC) begin : g_bad_data
      $error("pkt_coalesce_irq: DATA_W too narrow for a field");
   end

   logic [THR_W-1:0] thr_q;
   logic [WB_W-1:0]  wb_q;
   logic [NSRC-1:0]  en_q;
   logic [CNT_W-1:0] cnt;
   logic [NSRC-1:0]  stat;
   logic [NSRC-1:0]  set_vec, tog_vec;
   logic             wr_thr, wr_wb, wr_en, wr_dec, wr_st;
   logic             thr_hit, run_t, tick, expire;

   assign wr_thr = reg_wr && (reg_addr == RA_THRESH) && !chan_run;
   assign wr_wb  = reg_wr && (reg_addr == RA_WAIT)   && !chan_run;
   assign wr_en  = reg_wr && (reg_addr == RA_ENABLE);
   assign wr_dec = reg_wr && (reg_addr == RA_COUNT);
   assign wr_st  = reg_wr && (reg_addr == RA_STATUS);

   always_ff @(posedge clk) begin
      if (rst) begin
         thr_q <= '0;
         wb_q  <= '0;
         en_q  <= '0;
      end else begin
         if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
         if (wr_wb)  wb_q  <= reg_wdata[WB_W-1:0];
         if (wr_en)  en_q  <= reg_wdata[NSRC-1:0];
      end
   end

   coal_pkt_count #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .inc(pkt_done), .dec(wr_dec), .cnt(cnt));

   assign thr_hit = (thr_q != '0) && (cnt >= CNT_W'(thr_q));
   assign run_t   = (cnt != '0) && (wb_q != '0);

   coal_ms_tick #(.DIV(TICK_DIV)) tick_i (
      .clk(clk), .rst(rst), .clr(!run_t || pkt_done), .tick(tick));

   coal_wait_timer #(.WB_W(WB_W)) timer_i (
      .clk(clk), .rst(rst), .run(run_t), .restart(pkt_done), .tick(tick),
      .bound(wb_q), .expire(expire));

   always_comb begin
      set_vec          = '0;
      set_vec[ST_THR]  = thr_hit;
      set_vec[ST_WAIT] = expire && !thr_hit;
      set_vec[ST_EOL]  = list_end;
      set_vec[ST_BUS]  = bus_fault;
      tog_vec          = wr_st ? reg_wdata[NSRC-1:0] : '0;
   end

   coal_irq_status #(.N(NSRC)) stat_i (
      .clk(clk), .rst(rst), .set(set_vec), .tog(tog_vec), .en(en_q),
      .stat(stat), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_THRESH: reg_rdata = DATA_W'(thr_q);
         RA_WAIT:   reg_rdata = DATA_W'(wb_q);
         RA_COUNT:  reg_rdata = DATA_W'(cnt);
         RA_STATUS: reg_rdata = DATA_W'(stat);
         RA_ENABLE: reg_rdata = DATA_W'(en_q);
         default:   reg_rdata = '0;
      endcase
   end

   assert_thr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      (chan_run && reg_wr && reg_addr == RA_THRESH) |=> $stable(thr_q));
   assert_wb_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      (chan_run && reg_wr && reg_addr == RA_WAIT) |=> $stable(wb_q));
   assert_thr_sets_R3: assert property (@(posedge clk) disable iff (rst)
      thr_hit |=> stat[ST_THR]);
   assert_wait_needs_pkts_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(stat[ST_WAIT]) && !$past(wr_st)) |-> $past(cnt != '0 && !thr_hit));
endmodule

// File: tb/pkt_coalesce_irq_tb_top.sv
module pkt_coalesce_irq_tb_top;
   localparam int DW = 16;
   localparam int DIV = 8;

   logic clk = 0, rst = 1, chan_run = 0, pkt_done = 0, list_end = 0, bus_fault = 0;
   logic reg_wr = 0;
   logic [2:0] reg_addr = 0;
   logic [DW-1:0] reg_wdata = 0;
   logic [DW-1:0] reg_rdata;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pkt_coalesce_irq #(.THR_W(8), .CNT_W(8), .WB_W(10), .DATA_W(DW), .TICK_DIV(DIV)) dut_i (
      .clk(clk), .rst(rst), .chan_run(chan_run), .pkt_done(pkt_done),
      .list_end(list_end), .bus_fault(bus_fault), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   function automatic int next_cnt(int c, bit inc, bit dec);
      int ie = (inc && c != 255) ? 1 : 0;
      int de = (dec && c != 0) ? 1 : 0;
      return c + ie - de;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, input int exp, input string req);
      reg_addr = a;
      #1;
      chk(reg_rdata == DW'(exp), req, int'(reg_rdata), exp);
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic pkt();
      pkt_done = 1;
      @(negedge clk);
      pkt_done = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1;
      idle(3);
      rst = 0;
   endtask

   initial begin
      int thr, m_cnt;
      bit m_st0, m_irq;
      void'($urandom(32'd20240607));
      do_reset();
      // R1 reset state
      for (int a = 0; a < 6; a++) rd(3'(a), 0, "R1 reg after reset");
      chk(irq == 0, "R1 irq after reset", irq, 0);

      // R9 configuration while stopped, masking of wait bound
      wr(0, 3);
      wr(1, 16'h07FF);
      rd(1, 16'h3FF, "R9 wait bound masked");
      wr(4, 16'hF);
      chan_run = 1;
      wr(0, 9);
      rd(0, 3, "R9 threshold frozen while running");
      wr(1, 5);
      rd(1, 16'h3FF, "R9 wait bound frozen while running");
      chan_run = 0;
      wr(1, 0);

      // R3 / R10 threshold reached
      pkt(); pkt();
      rd(2, 2, "R2 count after two packets");
      rd(3, 0, "R3 below threshold");
      pkt();
      rd(3, 0, "R3 not yet set in count edge");
      idle(1);
      rd(3, 1, "R3 threshold bit set");
      chk(irq == 0, "R10 irq one cycle behind", irq, 0);
      idle(1);
      chk(irq == 1, "R10 irq raised", irq, 1);

      // R4 level behaviour
      wr(3, 1);
      rd(3, 1, "R4 ack while count meets threshold");
      wr(2, 16'hABCD);
      rd(2, 2, "R2 decrement");
      wr(3, 1);
      rd(3, 0, "R4 ack below threshold clears");
      idle(1);
      chk(irq == 0, "R10 irq dropped", irq, 0);
      wr(2, 0); wr(2, 0); wr(2, 0);
      rd(2, 0, "R2 decrement at zero ignored");

      // R8 toggle sets, R7 events
      wr(3, 4);
      rd(3, 4, "R8 toggle sets a clear bit");
      wr(3, 4);
      rd(3, 0, "R8 toggle clears");
      list_end = 1; @(negedge clk); list_end = 0;
      rd(3, 4, "R7 end of list");
      bus_fault = 1; @(negedge clk); bus_fault = 0;
      rd(3, 12, "R7 bus error");
      wr(3, 12);
      rd(3, 0, "R8 clear events");

      // R5 wait bound expiry
      wr(1, 2);
      pkt();
      idle(15);
      rd(3, 0, "R5 wait not yet expired");
      idle(1);
      rd(3, 2, "R5 wait expired");
      wr(3, 2);
      wr(2, 0);
      pkt();
      idle(10);
      pkt();
      idle(15);
      rd(3, 0, "R5 restart on new packet");
      idle(1);
      rd(3, 2, "R5 expiry after restart");
      wr(3, 2);
      pkt();
      idle(20);
      rd(3, 1, "R5 suppressed when threshold met");
      wr(2, 0); wr(2, 0); wr(2, 0);
      wr(3, 1);
      rd(3, 0, "R4 cleared after drain");

      // R6 wait bound zero
      wr(1, 0);
      pkt();
      idle(40);
      rd(3, 0, "R6 timer disabled");
      wr(2, 0);

      // R3 threshold zero
      wr(0, 0);
      repeat (5) pkt();
      idle(2);
      rd(3, 0, "R3 zero threshold disabled");
      repeat (5) wr(2, 0);

      // R2 saturation
      pkt_done = 1;
      idle(300);
      pkt_done = 0;
      rd(2, 255, "R2 saturation");
      wr(2, 0);
      rd(2, 254, "R2 decrement from saturation");

      // R8 stale write after reset
      do_reset();
      rd(3, 0, "R1 status cleared by reset");
      wr(3, 16'hF);
      rd(3, 15, "R8 stale write sets bits");

      // random phase with model
      do_reset();
      thr = 1 + int'($urandom % 8);
      wr(0, 16'(thr));
      wr(4, 1);
      m_cnt = 0; m_st0 = 0; m_irq = 0;
      reg_addr = 2;
      for (int i = 0; i < 600; i++) begin
         bit inc, dec;
         #1;
         chk(reg_rdata == DW'(m_cnt), "R2 random count", int'(reg_rdata), m_cnt);
         chk(irq == m_irq, "R10 random irq", irq, m_irq);
         inc = ($urandom % 2) == 0;
         dec = ($urandom % 3) == 0;
         pkt_done = inc; reg_wr = dec; reg_wdata = 0;
         @(posedge clk);
         m_irq = m_st0;
         if (m_cnt >= thr) m_st0 = 1;
         m_cnt = next_cnt(m_cnt, inc, dec);
         @(negedge clk);
      end
      pkt_done = 0; reg_wr = 0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule